// File: doc/BRIEF.md
# GPIO Port with Pin Multiplexing

This block is one 16-pin port of a combined general-purpose I/O and pin-function controller. Software reaches it through a 16-bit register interface. Each register holds one bit per pin. The registers set the output value of each pin, its direction, whether it runs as a plain port pin or hands the pad to one of eight peripheral functions, and how its input path and readback behave.

Every pin has its own mux. In port mode the pad is driven from the output-data latch and the direction bit. In alternate mode the pad output comes from the selected peripheral. The output enable then comes either from that peripheral or from the port direction bit, chosen by a per-pin enable. The pad level passes through a two-flop synchronizer. It is then qualified before it appears in the pin-state register, and it is also passed to the peripherals.

Several ports share one address map. Each register kind has its own region, and within a region a port sits at byte offset `PORT_ID*4`. The instance decodes only its own addresses.

Top module: `gpio_pinmux_port`

## Requirements
- R1: After reset every register reads 0x0000 except the direction register, which reads 0xFFFF (all inputs). `pad_oe`, `pad_out` and `alt_in` are 0.
- R2: Registers are written in one cycle. A read issued with `bus_rd` returns the data on `bus_rdata` one clock later, and `bus_rdata` holds until the next read. Addresses are region + `PORT_ID*4`, with these regions: 0x0000 output data, 0x0200 pin state (read only), 0x0300 direction, 0x0400 mode, 0x0500/0x0600/0x0A00 function-select bits 0/1/2, 0x4000 input-buffer enable, 0x4100 bidirectional enable, 0x4200 peripheral-direction enable.
- R3: An access to any other address reads 0x0000 and its write changes nothing. This includes the same region at another port's offset. Writes to the pin-state register are ignored.
- R4: In port mode (mode bit 0), direction bit 0 gives `pad_oe`=1 and `pad_out` = output-data bit. Direction bit 1 gives `pad_oe`=0 and `pad_out`=0. The output-data latch accepts writes in every mode, but only port-mode outputs show it on the pad.
- R5: In alternate mode (mode bit 1) the function index is {bit2, bit1, bit0} of the three select registers. `pad_out[p]` = `alt_out[f*16+p]` for that index f.
- R6: In alternate mode with the peripheral-direction bit set, `pad_oe[p]` = `alt_oe[f*16+p]`. With it clear, `pad_oe[p]` is the inverse of the direction bit.
- R7: A pin whose input buffer is disabled reads 0 in the pin-state register, whatever its pad level.
- R8: A pin with its input buffer enabled and its pad not driven reads its pad level in the pin-state register. The level comes through a two-flop synchronizer.
- R9: A pin whose pad is driven by the block reads its level only when its bidirectional bit is set, and reads 0 otherwise.
- R10: `alt_in[p]` carries the synchronized pad level of pins in alternate mode and is 0 for pins in port mode.
- R11: `pad_out` and `pad_oe` are registered: a register write becomes visible on the pad one clock after the write takes effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 16 | Write data, one bit per pin |
| bus_rdata | output | 16 | Registered read data |
| pad_in | input | 16 | Pad input levels |
| pad_out | output | 16 | Pad output levels |
| pad_oe | output | 16 | Pad output enables |
| alt_out | input | 128 | Peripheral outputs, function f pin p at bit f*16+p |
| alt_oe | input | 128 | Peripheral output enables, same layout |
| alt_in | output | 16 | Synchronized pad level to peripherals |

## Verification
A corrupted mode, select or direction bit shows on `pad_out` or `pad_oe` two clocks after the write that set it. This delay is the register update plus the registered pad stage. A wrong input-buffer or bidirectional bit shows only when the pin-state register is read, after the pad has crossed the two synchronizer flops. The bench therefore waits at least three clocks after changing a pad level before reading. A decode error shows as a readback mismatch on the very next read. Patterns that give each pin a different function index check that the select bits are not swapped.

// File: rtl/gpiop_pkg.sv
package gpiop_pkg;
  localparam int unsigned GP_ADDR_W      = 16;
  localparam int unsigned GP_PORT_STRIDE = 4;
  localparam int unsigned GP_FSEL_W      = 3;

  localparam int unsigned GP_OFF_DATA  = 32'h0000;
  localparam int unsigned GP_OFF_STATE = 32'h0200;
  localparam int unsigned GP_OFF_DIR   = 32'h0300;
  localparam int unsigned GP_OFF_MODE  = 32'h0400;
  localparam int unsigned GP_OFF_FS0   = 32'h0500;
  localparam int unsigned GP_OFF_FS1   = 32'h0600;
  localparam int unsigned GP_OFF_FS2   = 32'h0A00;
  localparam int unsigned GP_OFF_IBUF  = 32'h4000;
  localparam int unsigned GP_OFF_BIDIR = 32'h4100;
  localparam int unsigned GP_OFF_PDIR  = 32'h4200;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_STATE, SEL_DIR, SEL_MODE,
    SEL_FS0, SEL_FS1, SEL_FS2, SEL_IBUF, SEL_BIDIR, SEL_PDIR
  } gp_sel_e;
endpackage

// File: rtl/gpiop_sync.sv
module gpiop_sync #(
  parameter int unsigned W      = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] st;

  always_ff @(posedge clk) begin
    if (rst) st[0] <= '0;
    else     st[0] <= d;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[s] <= '0;
      else     st[s] <= st[s-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpiop_regfile.sv
module gpiop_regfile
  import gpiop_pkg::*;
#(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned ADDR_W  = GP_ADDR_W,
  parameter int unsigned PORT_ID = 3,
  parameter int unsigned FSEL_W  = GP_FSEL_W
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          bus_wr,
  input  logic                          bus_rd,
  input  logic [ADDR_W-1:0]             bus_addr,
  input  logic [NPINS-1:0]              bus_wdata,
  output logic [NPINS-1:0]              bus_rdata,
  input  logic [NPINS-1:0]              pin_state,
  output logic [NPINS-1:0]              data_q,
  output logic [NPINS-1:0]              dir_q,
  output logic [NPINS-1:0]              mode_q,
  output logic [FSEL_W-1:0][NPINS-1:0]  fsel_q,
  output logic [NPINS-1:0]              ibuf_q,
  output logic [NPINS-1:0]              bidir_q,
  output logic [NPINS-1:0]              pdir_q
);
  localparam int unsigned PORT_OFS = PORT_ID * GP_PORT_STRIDE;

  gp_sel_e          sel;
  logic [NPINS-1:0] rd_mux;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == ADDR_W'(GP_OFF_DATA  + PORT_OFS)) sel = SEL_DATA;
    else if (bus_addr == ADDR_W'(GP_OFF_STATE + PORT_OFS)) sel = SEL_STATE;
    else if (bus_addr == ADDR_W'(GP_OFF_DIR   + PORT_OFS)) sel = SEL_DIR;
    else if (bus_addr == ADDR_W'(GP_OFF_MODE  + PORT_OFS)) sel = SEL_MODE;
    else if (bus_addr == ADDR_W'(GP_OFF_FS0   + PORT_OFS)) sel = SEL_FS0;
    else if (bus_addr == ADDR_W'(GP_OFF_FS1   + PORT_OFS)) sel = SEL_FS1;
    else if (bus_addr == ADDR_W'(GP_OFF_FS2   + PORT_OFS)) sel = SEL_FS2;
    else if (bus_addr == ADDR_W'(GP_OFF_IBUF  + PORT_OFS)) sel = SEL_IBUF;
    else if (bus_addr == ADDR_W'(GP_OFF_BIDIR + PORT_OFS)) sel = SEL_BIDIR;
    else if (bus_addr == ADDR_W'(GP_OFF_PDIR  + PORT_OFS)) sel = SEL_PDIR;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      dir_q   <= '1;
      mode_q  <= '0;
      fsel_q  <= '0;
      ibuf_q  <= '0;
      bidir_q <= '0;
      pdir_q  <= '0;
    end else if (bus_wr) begin
      case (sel)
        SEL_DATA:  data_q    <= bus_wdata;
        SEL_DIR:   dir_q     <= bus_wdata;
        SEL_MODE:  mode_q    <= bus_wdata;
        SEL_FS0:   fsel_q[0] <= bus_wdata;
        SEL_FS1:   fsel_q[1] <= bus_wdata;
        SEL_FS2:   fsel_q[2] <= bus_wdata;
        SEL_IBUF:  ibuf_q    <= bus_wdata;
        SEL_BIDIR: bidir_q   <= bus_wdata;
        SEL_PDIR:  pdir_q    <= bus_wdata;
        default:   ;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_DATA:  rd_mux = data_q;
      SEL_STATE: rd_mux = pin_state;
      SEL_DIR:   rd_mux = dir_q;
      SEL_MODE:  rd_mux = mode_q;
      SEL_FS0:   rd_mux = fsel_q[0];
      SEL_FS1:   rd_mux = fsel_q[1];
      SEL_FS2:   rd_mux = fsel_q[2];
      SEL_IBUF:  rd_mux = ibuf_q;
      SEL_BIDIR: rd_mux = bidir_q;
      SEL_PDIR:  rd_mux = pdir_q;
      default:   rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/gpiop_pin_mux.sv
module gpiop_pin_mux #(
  parameter int unsigned FSEL_W = 3,
  parameter int unsigned NFUNC  = 1 << FSEL_W
) (
  input  logic              mode,
  input  logic              dir,
  input  logic              pdir,
  input  logic              data,
  input  logic [FSEL_W-1:0] fsel,
  input  logic [NFUNC-1:0]  alt_out,
  input  logic [NFUNC-1:0]  alt_oe,
  output logic              drv_out,
  output logic              drv_oe
);
  always_comb begin
    if (mode) begin
      drv_out = alt_out[fsel];
      drv_oe  = pdir ? alt_oe[fsel] : ~dir;
    end else begin
      drv_out = data & ~dir;
      drv_oe  = ~dir;
    end
  end
endmodule

// File: rtl/gpio_pinmux_port.sv
module gpio_pinmux_port
  import gpiop_pkg::*;
#(
  parameter int unsigned NPINS       = 16,
  parameter int unsigned ADDR_W      = GP_ADDR_W,
  parameter int unsigned PORT_ID     = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FSEL_W      = GP_FSEL_W,
  parameter int unsigned NFUNC       = 1 << FSEL_W
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bus_wr,
  input  logic                   bus_rd,
  input  logic [ADDR_W-1:0]      bus_addr,
  input  logic [NPINS-1:0]       bus_wdata,
  output logic [NPINS-1:0]       bus_rdata,
  input  logic [NPINS-1:0]       pad_in,
  output logic [NPINS-1:0]       pad_out,
  output logic [NPINS-1:0]       pad_oe,
  input  logic [NFUNC*NPINS-1:0] alt_out,
  input  logic [NFUNC*NPINS-1:0] alt_oe,
  output logic [NPINS-1:0]       alt_in
);
  logic [NPINS-1:0]             data_q, dir_q, mode_q, ibuf_q, bidir_q, pdir_q;
  logic [FSEL_W-1:0][NPINS-1:0] fsel_q;
  logic [NPINS-1:0]             pad_sync, pin_state, drv_out, drv_oe;

  gpiop_regfile #(
    .NPINS(NPINS), .ADDR_W(ADDR_W), .PORT_ID(PORT_ID), .FSEL_W(FSEL_W)
  ) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_state(pin_state), .data_q(data_q), .dir_q(dir_q),
    .mode_q(mode_q), .fsel_q(fsel_q), .ibuf_q(ibuf_q),
    .bidir_q(bidir_q), .pdir_q(pdir_q)
  );

  gpiop_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic [FSEL_W-1:0] pin_fsel;
    logic [NFUNC-1:0]  pin_alt_out, pin_alt_oe;
    for (genvar b = 0; b < FSEL_W; b++) begin : g_fs
      assign pin_fsel[b] = fsel_q[b][p];
    end
    for (genvar f = 0; f < NFUNC; f++) begin : g_fn
      assign pin_alt_out[f] = alt_out[f*NPINS + p];
      assign pin_alt_oe[f]  = alt_oe[f*NPINS + p];
    end
    gpiop_pin_mux #(.FSEL_W(FSEL_W), .NFUNC(NFUNC)) u_mux (
      .mode(mode_q[p]), .dir(dir_q[p]), .pdir(pdir_q[p]), .data(data_q[p]),
      .fsel(pin_fsel), .alt_out(pin_alt_out), .alt_oe(pin_alt_oe),
      .drv_out(drv_out[p]), .drv_oe(drv_oe[p])
    );
  end

  // Readable only with the input buffer on, and, when driven, with bidir on.
  assign pin_state = pad_sync & ibuf_q & (~pad_oe | bidir_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_out <= '0;
      pad_oe  <= '0;
      alt_in  <= '0;
    end else begin
      pad_out <= drv_out;
      pad_oe  <= drv_oe;
      alt_in  <= pad_sync & mode_q;
    end
  end
endmodule

// File: rtl/gpiop_checker.sv
module gpiop_checker
  import gpiop_pkg::*;
#(
  parameter int unsigned NPINS   = 16,
  parameter int unsigned ADDR_W  = GP_ADDR_W,
  parameter int unsigned PORT_ID = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_rdata,
  input logic [NPINS-1:0]  pad_out,
  input logic [NPINS-1:0]  pad_oe,
  input logic [NPINS-1:0]  dir_q,
  input logic [NPINS-1:0]  mode_q,
  input logic [NPINS-1:0]  ibuf_q
);
  localparam int unsigned PORT_OFS = PORT_ID * GP_PORT_STRIDE;
  logic hit_dir, hit_state;
  assign hit_dir   = bus_addr == ADDR_W'(GP_OFF_DIR + PORT_OFS);
  assign hit_state = bus_addr == ADDR_W'(GP_OFF_STATE + PORT_OFS);

  AST_PORT_OE: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pad_oe & ~$past(mode_q)) == (~$past(dir_q) & ~$past(mode_q)))); // R4
  AST_PORT_IN_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rst |=> ((pad_out & ~$past(mode_q) & $past(dir_q)) == '0)); // R4
  AST_DIR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && hit_dir) |=> $stable(dir_q)); // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata)); // R2
  AST_BUF_OFF_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && hit_state) |=> ((bus_rdata & ~$past(ibuf_q)) == '0)); // R7
endmodule

bind gpio_pinmux_port gpiop_checker #(
  .NPINS(NPINS), .ADDR_W(ADDR_W), .PORT_ID(PORT_ID)
) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
  .dir_q(dir_q), .mode_q(mode_q), .ibuf_q(ibuf_q)
);

// File: tb/tb_gpio_pinmux_port.sv
`timescale 1ns/1ps
module tb_gpio_pinmux_port;
  localparam int unsigned P = 3;
  localparam int unsigned N = 16;
  localparam int unsigned F = 8;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           bus_wr = 1'b0, bus_rd = 1'b0;
  logic [15:0]    bus_addr = '0, bus_wdata = '0;
  logic [N-1:0]   bus_rdata, pad_in, pad_out, pad_oe, alt_in;
  logic [N-1:0]   ext_lvl = '0;
  logic [F*N-1:0] alt_out = '0, alt_oe = '0;
  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  gpio_pinmux_port #(.PORT_ID(P)) dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in)
  );

  function automatic logic [15:0] ra(int unsigned off);
    return 16'(off + P*4);
  endfunction
  function automatic logic pat(int f, int p, int k);
    return 1'(((f*5 + p*3 + k) >> 1) & 1);
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask
  task automatic wr(logic [15:0] a, logic [15:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask
  task automatic rd(logic [15:0] a, output logic [15:0] d);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; d = bus_rdata;
  endtask
  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R1 pad_oe", pad_oe, 16'h0);
    chk("R1 pad_out", pad_out, 16'h0);
    chk("R1 alt_in", alt_in, 16'h0);
    rd(ra(32'h0300), v); chk("R1 dir", v, 16'hFFFF);
    rd(ra(32'h0000), v); chk("R1 data", v, 16'h0);
    rd(ra(32'h0400), v); chk("R1 mode", v, 16'h0);
    rd(ra(32'h4000), v); chk("R1 ibuf", v, 16'h0);
    rd(ra(32'h4200), v); chk("R1 pdir", v, 16'h0);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    wr(ra(32'h0A00), 16'h1357); rd(ra(32'h0A00), v); chk("R2 fs2", v, 16'h1357);
    wr(ra(32'h4100), 16'h2468); rd(ra(32'h4100), v); chk("R2 bidir", v, 16'h2468);
    wr(ra(32'h0500), 16'h9ABC); rd(ra(32'h0500), v); chk("R2 fs0", v, 16'h9ABC);
    wr(ra(32'h0A00), 16'h0); wr(ra(32'h4100), 16'h0); wr(ra(32'h0500), 16'h0);
  endtask

  task automatic t_unmapped();
    logic [15:0] v;
    wr(16'(32'h0300 + (P+1)*4), 16'h0000);
    rd(ra(32'h0300), v); chk("R3 other port write ignored", v, 16'hFFFF);
    rd(16'(32'h0300 + (P+1)*4), v); chk("R3 other port reads 0", v, 16'h0);
    wr(16'h0700, 16'hFFFF);
    rd(16'h0700, v); chk("R3 unmapped reads 0", v, 16'h0);
    wr(ra(32'h0200), 16'hFFFF);
    rd(ra(32'h0200), v); chk("R3 state write ignored", v, 16'h0);
  endtask

  task automatic t_port_mode();
    wr(ra(32'h0000), 16'h5AA5);
    wr(ra(32'h0300), 16'hFF00);
    idle(1);
    chk("R4 oe port", pad_oe, 16'h00FF);
    chk("R4 out port", pad_out, 16'h00A5);
  endtask

  task automatic t_alt();
    logic [15:0] v, eo, ee;
    for (int f = 0; f < 8; f++)
      for (int p = 0; p < 16; p++) begin
        alt_out[f*16+p] = pat(f, p, 0);
        alt_oe[f*16+p]  = pat(f, p, 1);
      end
    wr(ra(32'h0500), 16'hAAAA); wr(ra(32'h0600), 16'hCCCC);
    wr(ra(32'h0A00), 16'hF0F0);
    wr(ra(32'h0300), 16'h0F0F);
    wr(ra(32'h0400), 16'hFFFF);
    idle(1);
    for (int p = 0; p < 16; p++) begin
      eo[p] = pat(p & 7, p, 0);
      ee[p] = pat(p & 7, p, 1);
    end
    chk("R5 alt out", pad_out, eo);
    chk("R6 oe from dir", pad_oe, 16'hF0F0);
    wr(ra(32'h4200), 16'hFFFF);
    idle(1);
    chk("R6 oe from peripheral", pad_oe, ee);
    wr(ra(32'h0000), 16'h1234);
    idle(1);
    chk("R4 latch not on pad", pad_out, eo);
    rd(ra(32'h0000), v); chk("R4 latch updated", v, 16'h1234);
    for (int p = 0; p < 16; p++) alt_out[(p & 7)*16+p] = ~alt_out[(p & 7)*16+p];
    idle(2);
    chk("R11 alt pattern 2", pad_out, ~eo);
    wr(ra(32'h4200), 16'h0); wr(ra(32'h0400), 16'h0);
    wr(ra(32'h0300), 16'hFFFF);
  endtask

  task automatic t_readback();
    logic [15:0] v;
    ext_lvl = 16'hA5A5;
    idle(4);
    rd(ra(32'h0200), v); chk("R7 buffer off reads 0", v, 16'h0);
    wr(ra(32'h4000), 16'h00FF);
    idle(1);
    rd(ra(32'h0200), v); chk("R8 input partial buffer", v, 16'h00A5);
    wr(ra(32'h4000), 16'hFFFF);
    rd(ra(32'h0200), v); chk("R8 input level", v, 16'hA5A5);
    ext_lvl = 16'h5A5A;
    idle(4);
    rd(ra(32'h0200), v); chk("R8 input level 2", v, 16'h5A5A);
  endtask

  task automatic t_bidir();
    logic [15:0] v;
    wr(ra(32'h0000), 16'h3C3C);
    wr(ra(32'h0300), 16'h0000);
    idle(4);
    rd(ra(32'h0200), v); chk("R9 driven no bidir", v, 16'h0);
    wr(ra(32'h4100), 16'h0F0F);
    idle(1);
    rd(ra(32'h0200), v); chk("R9 driven bidir", v, 16'h0C0C);
    wr(ra(32'h0300), 16'hFFFF);
    wr(ra(32'h4100), 16'h0);
  endtask

  task automatic t_alt_in();
    ext_lvl = 16'hF00F;
    wr(ra(32'h0400), 16'h00FF);
    idle(4);
    chk("R10 alt_in", alt_in, 16'h000F);
    wr(ra(32'h0400), 16'h0);
    idle(2);
    chk("R10 port mode alt_in 0", alt_in, 16'h0);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_unmapped();
    t_port_mode();
    t_alt();
    wr(ra(32'h0300), 16'hFFFF);
    t_readback();
    t_bidir();
    t_alt_in();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule